// File: doc/BRIEF.md
# Busy-Poll Completion Timer

After a host has sent a command to a remote bridge device, this sequencer waits for the device to finish. It asks a link engine for single-bit reads. A read of 0 means the device is done. A read of 1 means it is still busy, and the sequencer waits before it asks again. The wait after the very first busy read covers the whole message: the per-byte time multiplied by the byte count. Every wait after that lasts one byte time. The per-byte time depends on the selected bus speed and is scaled by a stretch factor. All waits are counted in ticks of a 1 µs enable input. After a fixed number of retries the sequencer gives up and reports a timeout.

The caller places the bus speed code, the stretch factor and the total byte count on the inputs and pulses `start`. For a plain read or write the byte count is length+1. For a write followed by a read it is write length + 1 + read length + 1. The sequencer reports the end of the run with exactly one single-cycle pulse on `done`, `timeout` or `err`, and it then returns to idle.

The link port follows a request/acknowledge rule, which works as valid/ready. `bit_req` rises and stays high until the engine answers with `bit_ack` for one cycle. While `bit_ack` is high, `bit_val` carries the sampled bit and `bit_err` flags a link failure. The engine may hold back `bit_ack` for any number of cycles. The sequencer never withdraws a request.

Top module: `busy_poll_timer`

## Requirements
- R1: After reset, `bit_req`, `busy`, `done`, `timeout` and `err` are all low.
- R2: `start` is accepted only while idle, and the speed, stretch and byte count are captured at that moment. A `start` pulse, or new settings, during a run change neither that run's waits nor its outcome.
- R3: The first bit request is issued with no delay: `bit_req` is high in the cycle right after the cycle in which `start` is accepted.
- R4: An acknowledged sample with `bit_val`=0 (and `bit_err`=0) produces a `done` pulse. No further requests follow.
- R5: After the first sample that reads 1, the sequencer waits B×S×N ticks and then requests again. N is the byte count, S is the stretch value and B depends on the speed code: 0→90, 1→23, 2→10, 3→23.
- R6: After every later sample that reads 1, the wait is B×S ticks.
- R7: If all MAX_RETRY+1 samples read 1 (default 501), `timeout` pulses after the wait that follows the last sample.
- R8: An acknowledge with `bit_err`=1 ends the run at once with an `err` pulse and no further requests.
- R9: Once raised, `bit_req` stays high until the cycle in which `bit_ack` is seen.
- R10: A wait advances only on cycles where `tick` is high. While `tick` is low, no new request is made.
- R11: `done`, `timeout` and `err` are never high together. Each lasts exactly one cycle, and `busy` is low while any of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (accepted when idle) |
| speed_sel | input | 2 | Bus speed code: 0=100 kHz, 1=400 kHz, 2=900 kHz, 3=treated as 400 kHz |
| stretch | input | STRETCH_W | Per-byte time multiplier |
| byte_cnt | input | COUNT_W | Message byte count that scales the first wait |
| tick | input | 1 | 1 µs timebase enable |
| bit_req | output | 1 | Request for one bit sample from the link engine |
| bit_ack | input | 1 | Link engine answer, one cycle |
| bit_val | input | 1 | Sampled busy bit, valid with `bit_ack` |
| bit_err | input | 1 | Link failure, valid with `bit_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Device reported ready (pulse) |
| timeout | output | 1 | Retry limit exhausted (pulse) |
| err | output | 1 | Link engine error (pulse) |

## Verification
Assertions check on every cycle the properties that hold locally:
- the request stays up until acknowledged;
- the captured settings stay frozen while busy;
- the request follows an accepted start in the next cycle;
- the wait counter holds still on cycles with no tick;
- the retry counter never passes its limit;
- the status pulses are exclusive and single-cycle.

Only the bench scenarios can show the following:
- the wait lengths, which are the long first wait and the short later waits, for each speed code, including the fallback code;
- the exact count of 501 samples before a timeout;
- that an error mid-run stops the polling;
- that a stray start during a run leaves the measured waits unchanged.

// File: rtl/bpoll_pkg.sv
package bpoll_pkg;

  typedef enum logic [1:0] {
    SPD_100K = 2'd0,
    SPD_400K = 2'd1,
    SPD_900K = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  // width of the per-byte base time in microseconds
  localparam int unsigned BASE_W = 7;

  // time for one byte on the remote bus, in microseconds
  function automatic logic [BASE_W-1:0] byte_time_us(input speed_e spd);
    logic [BASE_W-1:0] t;
    case (spd)
      SPD_100K: t = BASE_W'(90);
      SPD_900K: t = BASE_W'(10);
      default:  t = BASE_W'(23);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bpoll_delay_calc.sv
module bpoll_delay_calc
  import bpoll_pkg::*;
#(
  parameter int unsigned STRETCH_W = 4,
  parameter int unsigned COUNT_W   = 10,
  parameter int unsigned DLY_W     = BASE_W + STRETCH_W + COUNT_W
) (
  input  speed_e               speed,
  input  logic [STRETCH_W-1:0] stretch,
  input  logic [COUNT_W-1:0]   nbytes,
  output logic [DLY_W-1:0]     short_dly,
  output logic [DLY_W-1:0]     long_dly
);

  localparam int unsigned UNIT_W = BASE_W + STRETCH_W;

  logic [UNIT_W-1:0] unit_us;

  always_comb begin
    unit_us   = {{STRETCH_W{1'b0}}, byte_time_us(speed)} * {{BASE_W{1'b0}}, stretch};
    short_dly = DLY_W'({{COUNT_W{1'b0}}, unit_us});
    long_dly  = DLY_W'({{COUNT_W{1'b0}}, unit_us} * {{UNIT_W{1'b0}}, nbytes});
  end

endmodule

// File: rtl/bpoll_tick_timer.sv
module bpoll_tick_timer #(
  parameter int unsigned W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                       remain <= '0;
    else if (load)                    remain <= load_val;
    else if (tick && remain != '0)    remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R10: without a tick (and no reload) the remaining time cannot move
  p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(remain));

endmodule

// File: rtl/bpoll_retry_ctr.sv
module bpoll_retry_ctr #(
  parameter int unsigned MAX_RETRY = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic first,
  output logic at_limit
);

  localparam int unsigned RW = $clog2(MAX_RETRY + 1);

  logic [RW-1:0] used;

  always_ff @(posedge clk) begin
    if (!rst_n)     used <= '0;
    else if (clear) used <= '0;
    else if (step)  used <= used + 1'b1;
  end

  assign first    = (used == '0);
  assign at_limit = (used == RW'(MAX_RETRY));

  // R7: the sequencer must never request a retry beyond the limit
  p_no_step_past_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_limit);

  p_retry_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used <= RW'(MAX_RETRY));

endmodule

// File: rtl/busy_poll_timer.sv
module busy_poll_timer
  import bpoll_pkg::*;
#(
  parameter int unsigned STRETCH_W = 4,
  parameter int unsigned COUNT_W   = 10,
  parameter int unsigned MAX_RETRY = 500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           speed_sel,
  input  logic [STRETCH_W-1:0] stretch,
  input  logic [COUNT_W-1:0]   byte_cnt,
  input  logic                 tick,
  output logic                 bit_req,
  input  logic                 bit_ack,
  input  logic                 bit_val,
  input  logic                 bit_err,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout,
  output logic                 err
);

  localparam int unsigned DLY_W = BASE_W + STRETCH_W + COUNT_W;

  state_e               state, state_nx;
  speed_e               cfg_speed;
  logic [STRETCH_W-1:0] cfg_stretch;
  logic [COUNT_W-1:0]   cfg_bytes;

  logic [DLY_W-1:0] short_dly, long_dly;
  logic             first_wait, at_limit, expired;
  logic             launch, accept, saw_busy, wait_over, rc_step;

  assign launch    = (state == ST_IDLE) && start;
  assign accept    = (state == ST_POLL) && bit_ack;
  assign saw_busy  = accept && !bit_err && bit_val;
  assign wait_over = (state == ST_WAIT) && expired;
  assign rc_step   = wait_over && !at_limit;

  bpoll_delay_calc #(
    .STRETCH_W(STRETCH_W), .COUNT_W(COUNT_W), .DLY_W(DLY_W)
  ) u_calc (
    .speed(cfg_speed), .stretch(cfg_stretch), .nbytes(cfg_bytes),
    .short_dly(short_dly), .long_dly(long_dly)
  );

  bpoll_tick_timer #(.W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(saw_busy),
    .load_val(first_wait ? long_dly : short_dly),
    .tick(tick), .expired(expired)
  );

  bpoll_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(launch), .step(rc_step),
    .first(first_wait), .at_limit(at_limit)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start)   state_nx = ST_POLL;
      ST_POLL: if (bit_ack) state_nx = saw_busy ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (expired) state_nx = at_limit ? ST_IDLE : ST_POLL;
      default:              state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cfg_speed   <= SPD_400K;
      cfg_stretch <= STRETCH_W'(1);
      cfg_bytes   <= '0;
      done        <= 1'b0;
      timeout     <= 1'b0;
      err         <= 1'b0;
    end else begin
      state   <= state_nx;
      done    <= accept && !bit_err && !bit_val;
      err     <= accept && bit_err;
      timeout <= wait_over && at_limit;
      if (launch) begin
        cfg_speed   <= speed_e'(speed_sel);
        cfg_stretch <= stretch;
        cfg_bytes   <= byte_cnt;
      end
    end
  end

  assign bit_req = (state == ST_POLL);
  assign busy    = (state != ST_IDLE);

  // R9: a raised request is held until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_ack) |=> bit_req);

  // R3: an accepted start is followed directly by a request
  p_first_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> bit_req);

  // R2: captured settings cannot change during a run
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_speed) && $stable(cfg_stretch) && $stable(cfg_bytes)));

  // R11: exclusive single-cycle status pulses, issued from idle
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout, err}));

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout || err) |=> !(done || timeout || err));

  p_pulse_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout || err) |-> !busy);

endmodule

// File: tb/busy_poll_timer_test.sv
module busy_poll_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] speed_sel = '0;
  logic [3:0] stretch = 4'd1;
  logic [9:0] byte_cnt = '0;
  logic       tick_en = 1'b1;
  logic       tick;
  logic       bit_req, bit_ack = 1'b0, bit_val = 1'b0, bit_err = 1'b0;
  logic       busy, done, timeout, err;

  assign tick = tick_en;

  always #4 clk = ~clk;

  busy_poll_timer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .speed_sel(speed_sel),
    .stretch(stretch), .byte_cnt(byte_cnt), .tick(tick),
    .bit_req(bit_req), .bit_ack(bit_ack), .bit_val(bit_val), .bit_err(bit_err),
    .busy(busy), .done(done), .timeout(timeout), .err(err)
  );

  int total = 0, failed = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // responder model of the link engine
  int samples = 0, ones_n = 0, err_at = -1, ack_wait = 0, hold_cnt = 0, req_dropped = 0;
  int ack_cyc = 0, first_req_cyc = -1, ngaps = 0, start_cyc = 0;
  int gaps [0:7];
  int n_done = 0, n_to = 0, n_err = 0;

  always @(negedge clk) begin
    if (done)    n_done++;
    if (timeout) n_to++;
    if (err)     n_err++;
    if (bit_ack) begin
      bit_ack = 1'b0;
    end else if (bit_req) begin
      if (hold_cnt < ack_wait) hold_cnt++;
      else begin
        hold_cnt = 0;
        if (samples == 0) first_req_cyc = cyc;
        else if (ngaps < 8 && ack_wait == 0) begin gaps[ngaps] = cyc - ack_cyc; ngaps++; end
        bit_ack = 1'b1;
        bit_val = (samples < ones_n);
        bit_err = (samples == err_at);
        ack_cyc = cyc;
        samples++;
      end
    end else if (hold_cnt != 0) begin
      req_dropped++;
      hold_cnt = 0;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int spd, input int str, input int nb, input int ones,
                     input int errat, input bit poke);
    int guard = 0;
    @(negedge clk);
    speed_sel = 2'(spd); stretch = 4'(str); byte_cnt = 10'(nb);
    ones_n = ones; err_at = errat; samples = 0; ngaps = 0; first_req_cyc = -1;
    n_done = 0; n_to = 0; n_err = 0; req_dropped = 0;
    start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; speed_sel = 2'd2; stretch = 4'd5; byte_cnt = 10'd9;
      @(negedge clk);
      start = 1'b0;
    end
    while ((n_done + n_to + n_err) == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // speed, stretch, bytes, ones before zero, expected long wait, expected short wait
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0, 1, 3, 2, 270, 90},
    '{1, 2, 4, 3, 184, 46},
    '{2, 1, 2, 1,  20, 10},
    '{3, 1, 5, 2, 115, 23},
    '{0, 3, 1, 0,   0,  0},
    '{2, 2, 6, 4, 120, 20}
  };

  initial begin
    #(8 * 150000);
    failed++; total++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check_eq("R1 bit_req after reset", int'(bit_req), 0);
    check_eq("R1 busy after reset", int'(busy), 0);
    check_eq("R1 status after reset", int'({done, timeout, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], -1, 1'b0);
      check_eq($sformatf("R3 v%0d start to request", v), first_req_cyc - start_cyc, 1);
      check_eq($sformatf("R4 v%0d done pulses", v), n_done, 1);
      check_eq($sformatf("R4 v%0d samples", v), samples, VEC[v][3] + 1);
      check_eq($sformatf("R11 v%0d other pulses", v), n_to + n_err, 0);
      if (VEC[v][3] >= 1)
        check_eq($sformatf("R5 v%0d first wait", v), gaps[0], VEC[v][4] + 2);
      if (VEC[v][3] >= 2)
        check_eq($sformatf("R6 v%0d later wait", v), gaps[1], VEC[v][5] + 2);
      if (VEC[v][3] >= 3)
        check_eq($sformatf("R6 v%0d third wait", v), gaps[2], VEC[v][5] + 2);
      check_eq($sformatf("R11 v%0d idle after", v), int'(busy), 0);
    end

    // R2: stray start with new settings during a run
    run(0, 1, 2, 2, -1, 1'b1);
    check_eq("R2 first wait unchanged", gaps[0], 180 + 2);
    check_eq("R2 later wait unchanged", gaps[1], 90 + 2);
    check_eq("R2 single done", n_done, 1);

    // R8: link error on the second sample
    run(1, 1, 2, 5, 1, 1'b0);
    check_eq("R8 err pulses", n_err, 1);
    check_eq("R8 samples stop", samples, 2);
    check_eq("R8 no done", n_done, 0);
    check_eq("R8 no request after", int'(bit_req), 0);

    // R9: engine delays acknowledge
    ack_wait = 6;
    run(2, 1, 1, 2, -1, 1'b0);
    check_eq("R9 request never dropped", req_dropped, 0);
    check_eq("R9 done after slow acks", n_done, 1);
    ack_wait = 0;

    // R10: wait frozen while tick is low
    tick_en = 1'b0;
    fork
      run(2, 1, 1, 1, -1, 1'b0);
      begin
        wait (samples == 1);
        repeat (40) @(negedge clk);
        check_eq("R10 no resample without tick", samples, 1);
        check_eq("R10 request idle without tick", int'(bit_req), 0);
        tick_en = 1'b1;
      end
    join
    check_eq("R10 done once ticks resume", n_done, 1);

    // R7: device never clears its busy bit
    run(2, 1, 1, 100000, -1, 1'b0);
    check_eq("R7 timeout pulses", n_to, 1);
    check_eq("R7 sample count", samples, 501);
    check_eq("R7 no done", n_done, 0);
    check_eq("R7 idle after timeout", int'(busy), 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule